// File: doc/BRIEF.md
# Operand Address Generator

This block turns the six-bit operand specifier of an instruction (a three-bit mode and a three-bit register number) into either an operand address or an indication that the operand lives in a register or in the instruction stream. It also computes the new value of an address register when the mode steps that register before or after the access, and presents it on a writeback port for the register file to apply. The caller provides the operand size, up to two extension words that follow the opcode, the address of the first extension word, and the current contents of all eight data and eight address registers.

A request is accepted on the rising clock edge where `req_valid` is high. The result appears on the outputs one cycle later, together with `rsp_valid`. The block neither reads memory nor executes the instruction. Mode 111 is an escape: its register field picks one of five forms that need no base register (short or long absolute, program-counter relative with or without an index, and immediate data). The caller uses the extension-word count to advance past the extension words.

Top module: `eag_unit`

## Requirements
- R1: Mode 000 gives operand kind 0 (data register) and mode 001 gives kind 1 (address register), each with zero extension words, address 0 and no writeback.
- R2: Mode 010 gives kind 2 (memory) with the address equal to the selected address register, zero extension words and no writeback.
- R3: Mode 011 gives the selected address register as the address and writes back that register plus a step of 1, 2 or 4 for size code 00 (byte), 01 (word) or 10 (long); size code 11 steps like long.
- R4: Mode 100 subtracts the step from the selected address register, uses the result as the address and writes the same value back to that register.
- R5: A byte-sized step through address register 7 is 2 in both stepping modes, so the stack stays word aligned.
- R6: Mode 101 gives the selected address register plus the sign-extended extension word 0, and one extension word.
- R7: Mode 110 reads extension word 0 as an index word: bit 15 picks the index file (0 data, 1 address), bits 14:12 the index register, bit 11 the index size (0 low 16 bits sign-extended, 1 full 32 bits) and bits 7:0 a signed displacement. The address is the base register plus the displacement plus the index value, with one extension word.
- R8: Mode 111 with register code 000 gives the sign-extended extension word 0 (one word); code 001 gives extension word 0 as the upper half and extension word 1 as the lower half of the address (two words).
- R9: Mode 111 codes 010 and 011 use the address of the first extension word as base: code 010 adds the sign-extended extension word 0, code 011 applies the index word of R7 to that base; each uses one extension word.
- R10: Mode 111 code 100 gives kind 3 (immediate) with the address equal to the first extension word address, one extension word for byte or word size and two for long.
- R11: Mode 111 codes 101, 110 and 111 raise the illegal flag with zero extension words, address 0 and no writeback.
- R12: Each accepted request gives exactly one response one cycle later; `rsp_valid` is low in every other cycle and all outputs are zero after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe |
| ea_mode | input | 3 | Mode field |
| ea_reg | input | 3 | Register field or escape sub-code |
| op_size | input | 2 | Operand size code |
| ext_w0 | input | 16 | First extension word |
| ext_w1 | input | 16 | Second extension word |
| pc_ext | input | AW | Address of the first extension word |
| areg_bus | input | 8*AW | Address registers, register n at bits n*AW |
| dreg_bus | input | 8*AW | Data registers, register n at bits n*AW |
| rsp_valid | output | 1 | Result valid |
| ea_out | output | AW | Operand address |
| opnd_kind | output | 2 | Operand kind code |
| ext_count | output | 2 | Extension words consumed |
| mode_bad | output | 1 | Illegal specifier |
| wb_en | output | 1 | Address register writeback strobe |
| wb_reg | output | 3 | Writeback register number |
| wb_val | output | AW | Writeback value |

## Verification
A wrong step size or a stepping mode that takes the old value where it should take the new one shows up in the same response cycle as a mismatch between `ea_out` and `wb_val`. A mis-decoded index word or escape code gives a wrong address or extension count on the very response for that request, one cycle after it is accepted. A stuck or extra response is visible at once as `rsp_valid` out of step with the request stream, which the scoreboard catches as an empty or non-empty queue.

// File: rtl/eag_pkg.sv
package eag_pkg;
   typedef enum logic [1:0] {
      OPK_DREG = 2'd0,
      OPK_AREG = 2'd1,
      OPK_MEM  = 2'd2,
      OPK_IMM  = 2'd3
   } opk_t;

   localparam logic [1:0] SZ_BYTE = 2'b00;
   localparam logic [1:0] SZ_WORD = 2'b01;

   localparam logic [2:0] M_DDIR = 3'b000;
   localparam logic [2:0] M_ADIR = 3'b001;
   localparam logic [2:0] M_IND  = 3'b010;
   localparam logic [2:0] M_PINC = 3'b011;
   localparam logic [2:0] M_PDEC = 3'b100;
   localparam logic [2:0] M_DISP = 3'b101;
   localparam logic [2:0] M_IDX  = 3'b110;

   localparam logic [2:0] X_ABSW = 3'b000;
   localparam logic [2:0] X_ABSL = 3'b001;
   localparam logic [2:0] X_PCD  = 3'b010;
   localparam logic [2:0] X_PCX  = 3'b011;
   localparam logic [2:0] X_IMM  = 3'b100;

   localparam int NREG = 8;
endpackage

// File: rtl/eag_step.sv
module eag_step #(
   parameter int AW       = 32,
   parameter int SP_IDX   = 7,
   parameter bit ALIGN_SP = 1'b1
) (
   input  logic [1:0]    size,
   input  logic [2:0]    rnum,
   output logic [AW-1:0] step
);
   import eag_pkg::*;

   logic [AW-1:0] natural_step;

   always_comb begin
      case (size)
         SZ_BYTE: natural_step = AW'(1);
         SZ_WORD: natural_step = AW'(2);
         default: natural_step = AW'(4);
      endcase
   end

   generate
      if (ALIGN_SP) begin : g_sp_align
         always_comb begin
            if (size == SZ_BYTE && rnum == 3'(SP_IDX)) step = AW'(2);
            else                                       step = natural_step;
         end
      end else begin : g_plain
         assign step = natural_step;
      end
   endgenerate
endmodule

// File: rtl/eag_index.sv
module eag_index #(
   parameter int AW = 32
) (
   input  logic          use_areg,
   input  logic [2:0]    idx_num,
   input  logic          idx_long,
   input  logic [7:0]    disp_raw,
   input  logic [AW-1:0] a_arr [eag_pkg::NREG],
   input  logic [AW-1:0] d_arr [eag_pkg::NREG],
   output logic [AW-1:0] offset
);
   logic [AW-1:0] sel_reg;
   logic [AW-1:0] idx_val;
   logic [AW-1:0] disp_ext;

   assign sel_reg  = use_areg ? a_arr[idx_num] : d_arr[idx_num];
   assign idx_val  = idx_long ? sel_reg : AW'($signed(sel_reg[15:0]));
   assign disp_ext = AW'($signed(disp_raw));
   assign offset   = idx_val + disp_ext;
endmodule

// File: rtl/eag_core.sv
module eag_core #(
   parameter int AW       = 32,
   parameter int SP_IDX   = 7,
   parameter bit ALIGN_SP = 1'b1
) (
   input  logic [2:0]    mode,
   input  logic [2:0]    regf,
   input  logic [1:0]    size,
   input  logic [15:0]   ext0,
   input  logic [15:0]   ext1,
   input  logic [AW-1:0] pc,
   input  logic [AW-1:0] a_arr [eag_pkg::NREG],
   input  logic [AW-1:0] d_arr [eag_pkg::NREG],
   output logic [AW-1:0] ea,
   output logic [1:0]    kind,
   output logic [1:0]    ext_n,
   output logic          illegal,
   output logic          wb_en,
   output logic [AW-1:0] wb_data
);
   import eag_pkg::*;

   logic [AW-1:0] step;
   logic [AW-1:0] idx_off;
   logic [AW-1:0] base_a;
   logic [AW-1:0] word_sx;

   eag_step #(.AW(AW), .SP_IDX(SP_IDX), .ALIGN_SP(ALIGN_SP)) u_step (
      .size (size),
      .rnum (regf),
      .step (step)
   );

   eag_index #(.AW(AW)) u_index (
      .use_areg (ext0[15]),
      .idx_num  (ext0[14:12]),
      .idx_long (ext0[11]),
      .disp_raw (ext0[7:0]),
      .a_arr    (a_arr),
      .d_arr    (d_arr),
      .offset   (idx_off)
   );

   assign base_a  = a_arr[regf];
   assign word_sx = AW'($signed(ext0));

   always_comb begin
      ea      = '0;
      kind    = OPK_MEM;
      ext_n   = 2'd0;
      illegal = 1'b0;
      wb_en   = 1'b0;
      wb_data = '0;
      case (mode)
         M_DDIR: kind = OPK_DREG;
         M_ADIR: kind = OPK_AREG;
         M_IND:  ea = base_a;
         M_PINC: begin
            ea      = base_a;
            wb_en   = 1'b1;
            wb_data = base_a + step;
         end
         M_PDEC: begin
            ea      = base_a - step;
            wb_en   = 1'b1;
            wb_data = base_a - step;
         end
         M_DISP: begin
            ea    = base_a + word_sx;
            ext_n = 2'd1;
         end
         M_IDX: begin
            ea    = base_a + idx_off;
            ext_n = 2'd1;
         end
         default: begin
            case (regf)
               X_ABSW: begin
                  ea    = word_sx;
                  ext_n = 2'd1;
               end
               X_ABSL: begin
                  ea    = AW'($signed({ext0, ext1}));
                  ext_n = 2'd2;
               end
               X_PCD: begin
                  ea    = pc + word_sx;
                  ext_n = 2'd1;
               end
               X_PCX: begin
                  ea    = pc + idx_off;
                  ext_n = 2'd1;
               end
               X_IMM: begin
                  kind  = OPK_IMM;
                  ea    = pc;
                  ext_n = (size[1]) ? 2'd2 : 2'd1;
               end
               default: illegal = 1'b1;
            endcase
         end
      endcase
   end
endmodule

// File: rtl/eag_unit.sv
module eag_unit #(
   parameter int AW       = 32,
   parameter int SP_IDX   = 7,
   parameter bit ALIGN_SP = 1'b1
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       req_valid,
   input  logic [2:0]                 ea_mode,
   input  logic [2:0]                 ea_reg,
   input  logic [1:0]                 op_size,
   input  logic [15:0]                ext_w0,
   input  logic [15:0]                ext_w1,
   input  logic [AW-1:0]              pc_ext,
   input  logic [eag_pkg::NREG*AW-1:0] areg_bus,
   input  logic [eag_pkg::NREG*AW-1:0] dreg_bus,
   output logic                       rsp_valid,
   output logic [AW-1:0]              ea_out,
   output logic [1:0]                 opnd_kind,
   output logic [1:0]                 ext_count,
   output logic                       mode_bad,
   output logic                       wb_en,
   output logic [2:0]                 wb_reg,
   output logic [AW-1:0]              wb_val
);
   import eag_pkg::*;

   generate
      if (AW < 32) begin : g_bad_aw
         $error("eag_unit: AW must be at least 32");
      end
      if (SP_IDX < 0 || SP_IDX >= NREG) begin : g_bad_sp
         $error("eag_unit: SP_IDX out of range");
      end
   endgenerate

   logic [AW-1:0] a_arr [NREG];
   logic [AW-1:0] d_arr [NREG];

   generate
      for (genvar g = 0; g < NREG; g++) begin : g_unpack
         assign a_arr[g] = areg_bus[g*AW +: AW];
         assign d_arr[g] = dreg_bus[g*AW +: AW];
      end
   endgenerate

   logic [AW-1:0] c_ea;
   logic [1:0]    c_kind;
   logic [1:0]    c_ext;
   logic          c_bad;
   logic          c_wb;
   logic [AW-1:0] c_wbv;

   eag_core #(.AW(AW), .SP_IDX(SP_IDX), .ALIGN_SP(ALIGN_SP)) u_core (
      .mode    (ea_mode),
      .regf    (ea_reg),
      .size    (op_size),
      .ext0    (ext_w0),
      .ext1    (ext_w1),
      .pc      (pc_ext),
      .a_arr   (a_arr),
      .d_arr   (d_arr),
      .ea      (c_ea),
      .kind    (c_kind),
      .ext_n   (c_ext),
      .illegal (c_bad),
      .wb_en   (c_wb),
      .wb_data (c_wbv)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         ea_out    <= '0;
         opnd_kind <= 2'd0;
         ext_count <= 2'd0;
         mode_bad  <= 1'b0;
         wb_en     <= 1'b0;
         wb_reg    <= 3'd0;
         wb_val    <= '0;
      end else begin
         rsp_valid <= req_valid;
         wb_en     <= req_valid & c_wb;
         if (req_valid) begin
            ea_out    <= c_ea;
            opnd_kind <= c_kind;
            ext_count <= c_ext;
            mode_bad  <= c_bad;
            wb_reg    <= ea_reg;
            wb_val    <= c_wbv;
         end
      end
   end

   a_r12_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> rsp_valid);
   a_r12_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !rsp_valid);
   a_r11_illegal_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && mode_bad) |-> (!wb_en && ext_count == 2'd0));
   a_r3_wb_step: assert property (@(posedge clk) disable iff (!rst_n)
      wb_en |-> (wb_val == ea_out || (wb_val - ea_out) == AW'(1) ||
                 (wb_val - ea_out) == AW'(2) || (wb_val - ea_out) == AW'(4)));
   a_r1_reg_no_ext: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && opnd_kind[1] == 1'b0) |-> (ext_count == 2'd0 && !wb_en));
   a_r8_ext_bound: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> ext_count != 2'd3);
   a_r4_wb_kind: assert property (@(posedge clk) disable iff (!rst_n)
      wb_en |-> (rsp_valid && opnd_kind == 2'd2));
endmodule

// File: tb/eag_unit_test.sv
module eag_unit_test;
   localparam int AW = 32;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            req_valid = 1'b0;
   logic [2:0]      ea_mode = '0;
   logic [2:0]      ea_reg = '0;
   logic [1:0]      op_size = '0;
   logic [15:0]     ext_w0 = '0;
   logic [15:0]     ext_w1 = '0;
   logic [AW-1:0]   pc_ext = '0;
   logic [8*AW-1:0] areg_bus = '0;
   logic [8*AW-1:0] dreg_bus = '0;
   logic            rsp_valid;
   logic [AW-1:0]   ea_out;
   logic [1:0]      opnd_kind;
   logic [1:0]      ext_count;
   logic            mode_bad;
   logic            wb_en;
   logic [2:0]      wb_reg;
   logic [AW-1:0]   wb_val;

   int n_checks = 0;
   int n_bad = 0;

   typedef struct {
      string       tag;
      logic [31:0] ea;
      logic [1:0]  kind;
      logic [1:0]  ext;
      logic        bad;
      logic        wb;
      logic [2:0]  wreg;
      logic [31:0] wval;
   } exp_t;

   exp_t sb[$];
   logic [31:0] ar [8];
   logic [31:0] dr [8];

   always #5 clk = ~clk;

   eag_unit #(.AW(AW)) uut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid),
      .ea_mode(ea_mode), .ea_reg(ea_reg), .op_size(op_size),
      .ext_w0(ext_w0), .ext_w1(ext_w1), .pc_ext(pc_ext),
      .areg_bus(areg_bus), .dreg_bus(dreg_bus),
      .rsp_valid(rsp_valid), .ea_out(ea_out), .opnd_kind(opnd_kind),
      .ext_count(ext_count), .mode_bad(mode_bad), .wb_en(wb_en),
      .wb_reg(wb_reg), .wb_val(wb_val)
   );

   function automatic logic [31:0] sx16(input logic [15:0] v);
      return {{16{v[15]}}, v};
   endfunction

   function automatic logic [31:0] idx_term(input logic [15:0] w);
      logic [31:0] r;
      r = w[15] ? ar[w[14:12]] : dr[w[14:12]];
      if (!w[11]) r = sx16(r[15:0]);
      return r + {{24{w[7]}}, w[7:0]};
   endfunction

   function automatic exp_t model(input string tag, input logic [2:0] m,
                                  input logic [2:0] r, input logic [1:0] sz,
                                  input logic [15:0] e0, input logic [15:0] e1,
                                  input logic [31:0] pc);
      exp_t x;
      logic [31:0] st;
      x = '{tag: tag, ea: 32'd0, kind: 2'd2, ext: 2'd0, bad: 1'b0,
            wb: 1'b0, wreg: r, wval: 32'd0};
      st = (sz == 2'b00) ? ((r == 3'd7) ? 32'd2 : 32'd1) :
           (sz == 2'b01) ? 32'd2 : 32'd4;
      if (m == 3'd0) x.kind = 2'd0;
      else if (m == 3'd1) x.kind = 2'd1;
      else if (m == 3'd2) x.ea = ar[r];
      else if (m == 3'd3) begin x.ea = ar[r]; x.wb = 1'b1; x.wval = ar[r] + st; end
      else if (m == 3'd4) begin x.ea = ar[r] - st; x.wb = 1'b1; x.wval = ar[r] - st; end
      else if (m == 3'd5) begin x.ea = ar[r] + sx16(e0); x.ext = 2'd1; end
      else if (m == 3'd6) begin x.ea = ar[r] + idx_term(e0); x.ext = 2'd1; end
      else if (r == 3'd0) begin x.ea = sx16(e0); x.ext = 2'd1; end
      else if (r == 3'd1) begin x.ea = {e0, e1}; x.ext = 2'd2; end
      else if (r == 3'd2) begin x.ea = pc + sx16(e0); x.ext = 2'd1; end
      else if (r == 3'd3) begin x.ea = pc + idx_term(e0); x.ext = 2'd1; end
      else if (r == 3'd4) begin x.kind = 2'd3; x.ea = pc; x.ext = sz[1] ? 2'd2 : 2'd1; end
      else x.bad = 1'b1;
      return x;
   endfunction

   task automatic send(input string tag, input logic [2:0] m, input logic [2:0] r,
                       input logic [1:0] sz, input logic [15:0] e0,
                       input logic [15:0] e1, input logic [31:0] pc);
      @(negedge clk);
      req_valid = 1'b1;
      ea_mode = m; ea_reg = r; op_size = sz;
      ext_w0 = e0; ext_w1 = e1; pc_ext = pc;
      sb.push_back(model(tag, m, r, sz, e0, e1, pc));
   endtask

   // monitor: compares every response against the head of the scoreboard
   initial begin
      forever begin
         @(negedge clk);
         #2;
         if (rst_n && rsp_valid) begin
            n_checks++;
            if (sb.size() == 0) begin
               n_bad++;
               $display("FAIL R12 response with empty queue: actual ea=%h expected none", ea_out);
            end else begin
               exp_t e;
               e = sb.pop_front();
               if (ea_out !== e.ea || opnd_kind !== e.kind || ext_count !== e.ext ||
                   mode_bad !== e.bad || wb_en !== e.wb ||
                   (e.wb && (wb_reg !== e.wreg || wb_val !== e.wval))) begin
                  n_bad++;
                  $display("FAIL %s actual ea=%h kind=%0d ext=%0d bad=%0b wb=%0b reg=%0d val=%h expected ea=%h kind=%0d ext=%0d bad=%0b wb=%0b reg=%0d val=%h",
                           e.tag, ea_out, opnd_kind, ext_count, mode_bad, wb_en, wb_reg, wb_val,
                           e.ea, e.kind, e.ext, e.bad, e.wb, e.wreg, e.wval);
               end
            end
         end
      end
   end

   initial begin
      #(200000 * 10);
      n_checks++;
      n_bad++;
      $display("FAIL watchdog expired: actual hung expected finish");
      $display("  test done: total=%0d bad=%0d", n_checks, n_bad);
      $finish;
   end

   initial begin
      for (int i = 0; i < 8; i++) begin
         ar[i] = 32'h1000 * (i + 1);
         dr[i] = 32'h11 * (i + 1);
      end
      ar[3] = 32'h0000_4001;
      ar[7] = 32'h0000_8000;
      dr[1] = 32'd6;
      dr[3] = 32'h0001_8000;
      for (int i = 0; i < 8; i++) begin
         areg_bus[i*32 +: 32] = ar[i];
         dreg_bus[i*32 +: 32] = dr[i];
      end
      repeat (3) @(negedge clk);
      #2;
      n_checks++;
      if (rsp_valid !== 1'b0 || wb_en !== 1'b0 || ea_out !== 32'd0) begin
         n_bad++;
         $display("FAIL R12 reset state: actual valid=%0b wb=%0b ea=%h expected 0 0 0",
                  rsp_valid, wb_en, ea_out);
      end
      @(negedge clk);
      rst_n = 1'b1;

      send("R1 data direct",        3'd0, 3'd2, 2'b10, 16'h0, 16'h0, 32'h0);
      send("R1 addr direct",        3'd1, 3'd5, 2'b10, 16'h0, 16'h0, 32'h0);
      send("R2 indirect",           3'd2, 3'd6, 2'b01, 16'h0, 16'h0, 32'h0);
      send("R3 postinc word",       3'd3, 3'd2, 2'b01, 16'h0, 16'h0, 32'h0);
      send("R3 postinc byte",       3'd3, 3'd3, 2'b00, 16'h0, 16'h0, 32'h0);
      send("R3 postinc long",       3'd3, 3'd4, 2'b10, 16'h0, 16'h0, 32'h0);
      send("R5 postinc byte sp",    3'd3, 3'd7, 2'b00, 16'h0, 16'h0, 32'h0);
      send("R4 predec long",        3'd4, 3'd1, 2'b10, 16'h0, 16'h0, 32'h0);
      send("R5 predec byte sp",     3'd4, 3'd7, 2'b00, 16'h0, 16'h0, 32'h0);
      send("R6 disp negative",      3'd5, 3'd5, 2'b01, 16'hFFF0, 16'h0, 32'h0);
      send("R7 index data word",    3'd6, 3'd0, 2'b01, 16'h3004, 16'h0, 32'h0);
      send("R7 index data long",    3'd6, 3'd0, 2'b01, 16'h3804, 16'h0, 32'h0);
      send("R7 index addr long",    3'd6, 3'd1, 2'b01, 16'hA8FE, 16'h0, 32'h0);
      send("R8 abs short negative", 3'd7, 3'd0, 2'b01, 16'h8000, 16'h0, 32'h0);
      send("R8 abs short positive", 3'd7, 3'd0, 2'b01, 16'h1234, 16'h0, 32'h0);
      send("R8 abs long",           3'd7, 3'd1, 2'b01, 16'h0012, 16'h3456, 32'h0);
      send("R9 pc disp",            3'd7, 3'd2, 2'b01, 16'h0100, 16'h0, 32'h1002);
      send("R9 pc index",           3'd7, 3'd3, 2'b01, 16'h1000 | 16'd100, 16'h0, 32'd1002);
      send("R10 imm byte",          3'd7, 3'd4, 2'b00, 16'h0, 16'h0, 32'h500);
      send("R10 imm long",          3'd7, 3'd4, 2'b10, 16'h0, 16'h0, 32'h500);
      send("R11 code 5",            3'd7, 3'd5, 2'b01, 16'h0, 16'h0, 32'h500);
      send("R11 code 7",            3'd7, 3'd7, 2'b10, 16'h0, 16'h0, 32'h500);
      @(negedge clk);
      req_valid = 1'b0;
      repeat (4) @(negedge clk);
      #3;
      n_checks++;
      if (sb.size() != 0 || rsp_valid !== 1'b0) begin
         n_bad++;
         $display("FAIL R12 drain: actual pending=%0d valid=%0b expected 0 0",
                  sb.size(), rsp_valid);
      end
      $display("  test done: total=%0d bad=%0d", n_checks, n_bad);
      $finish;
   end
endmodule